// File: doc/BRIEF.md
# Store Buffer with Youngest-Match Lookup

This block sits between a processor and its L1 data cache and holds stores that have been issued but not yet written into the cache. Each slot keeps one word address and one data word. Stores come in at the tail through a valid/ready port. The cache drains the oldest slot in the background through a second valid/ready port, which always shows the entry at the head.

Loads do not wait for the drain. A load presents its address on the lookup port. In the same cycle, every occupied slot is compared against it. If several slots hold the same address, the data of the store inserted last is returned. If no slot matches, the hit flag stays low and the requester uses the cache result instead.

Back-pressure works as follows. The enqueue port raises `enq_ready` while a slot is free. It also raises it when the buffer is full and the drain side accepts the head entry in that same cycle. The drain side may hold `deq_ready` low for as long as it likes. While it does, the head entry stays on `deq_addr` and `deq_data` unchanged. A transfer happens on a port only on a clock edge where its valid and ready are both high.

Top module: `stbuf_top`

## Requirements
- R1: After reset the buffer is empty: `deq_valid` is 0, `srch_hit` is 0 and `enq_ready` is 1.
- R2: Entries leave in arrival order. `deq_addr`/`deq_data` always show the oldest stored pair, and that pair holds steady while `deq_ready` is low.
- R3: With DEPTH entries held and `deq_ready` low, `enq_ready` is 0. A store offered then is not written: a later lookup of its address misses.
- R4: With DEPTH entries held and `deq_ready` high, `enq_ready` is 1. Both transfers take place and the occupancy stays at DEPTH.
- R5: A lookup returns `srch_hit`=1 and the data of the most recently enqueued occupied slot whose full address equals `srch_addr`, in the same cycle.
- R6: A lookup that matches no occupied slot returns `srch_hit`=0 and `srch_data`=0.
- R7: A lookup in the same cycle as an enqueue does not see the incoming store.
- R8: Youngest-match priority stays correct after the head and tail pointers wrap past the last slot.
- R9: `deq_valid` is 1 exactly when at least one slot is occupied.
- R10: Once an entry has been dequeued, its address no longer hits unless a younger slot holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store offered |
| enq_ready | output | 1 | Store accepted on this edge when valid |
| enq_addr | input | AW | Store word address |
| enq_data | input | DW | Store data |
| deq_valid | output | 1 | Head entry present |
| deq_ready | input | 1 | Drain side takes the head entry |
| deq_addr | output | AW | Oldest stored address |
| deq_data | output | DW | Oldest stored data |
| srch_addr | input | AW | Load lookup address |
| srch_hit | output | 1 | Some occupied slot matches |
| srch_data | output | DW | Youngest matching data, 0 on miss |

## Verification
Two things can fall in the same cycle: an enqueue and a dequeue while the buffer is full, and a lookup alongside an enqueue of the very address being searched. Both cases are set up on purpose. The buffer is filled, and a store is then offered with the drain held off and with the drain released. A store is also pushed while its own address is being searched. Each result is judged against a queue model in the bench. For the full case, the model expects ready high only when the drain accepts, and the occupancy to stay at DEPTH. For the lookup case, the model expects the result to reflect only the entries held before the edge. Random traffic over a small address set keeps both situations recurring while the pointers wrap.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'd0,
    FILL_PART  = 2'd1,
    FILL_FULL  = 2'd2
  } fill_e;

  // Slot index of the entry 'off' places after 'base', in a ring of 'depth'.
  function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                           int unsigned depth);
    int unsigned s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_fire,
  input  logic          deq_fire,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output fill_e         fill
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (deq_fire) head <= bump(head);
      if (enq_fire) tail <= bump(tail);
      case ({enq_fire, deq_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    if (count == '0)        fill = FILL_EMPTY;
    else if (count == FULL) fill = FILL_FULL;
    else                    fill = FILL_PART;
  end

endmodule

// File: rtl/stbuf_slots.sv
module stbuf_slots #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] slot_addr [DEPTH],
  output logic [DW-1:0] slot_data [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_addr[i] <= '0;
        slot_data[i] <= '0;
      end else if (wr_en && (wr_idx == PW'(i))) begin
        slot_addr[i] <= wr_addr;
        slot_data[i] <= wr_data;
      end
    end
  end

  assign rd_addr = slot_addr[rd_idx];
  assign rd_data = slot_data[rd_idx];

endmodule

// File: rtl/stbuf_search.sv
module stbuf_search
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [AW-1:0] slot_addr [DEPTH],
  input  logic [DW-1:0] slot_data [DEPTH],
  input  logic [PW-1:0] head,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] key,
  output logic          hit,
  output logic [DW-1:0] data
);

  // Match vector indexed by age: 0 is the oldest, DEPTH-1 the youngest possible.
  logic [DEPTH-1:0] age_hit;
  logic [DW-1:0]    age_data [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_age
    logic [PW-1:0] idx;
    always_comb begin
      idx         = PW'(ring_add(int'(head), a, DEPTH));
      age_hit[a]  = (CW'(a) < count) && (slot_addr[idx] == key);
      age_data[a] = slot_data[idx];
    end
  end

  // Later ages override earlier ones, so the youngest match wins.
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int a = 0; a < DEPTH; a++) begin
      if (age_hit[a]) begin
        hit  = 1'b1;
        data = age_data[a];
      end
    end
  end

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  output logic          deq_valid,
  input  logic          deq_ready,
  output logic [AW-1:0] deq_addr,
  output logic [DW-1:0] deq_data,
  input  logic [AW-1:0] srch_addr,
  output logic          srch_hit,
  output logic [DW-1:0] srch_data
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  fill_e         fill;
  logic          enq_fire, deq_fire;
  logic [AW-1:0] slot_addr [DEPTH];
  logic [DW-1:0] slot_data [DEPTH];

  assign deq_valid = (fill != FILL_EMPTY);
  assign enq_ready = (fill != FILL_FULL) || deq_ready;
  assign enq_fire  = enq_valid && enq_ready;
  assign deq_fire  = deq_valid && deq_ready;

  stbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_fire (enq_fire),
    .deq_fire (deq_fire),
    .head     (head),
    .tail     (tail),
    .count    (count),
    .fill     (fill)
  );

  stbuf_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (enq_fire),
    .wr_idx    (tail),
    .wr_addr   (enq_addr),
    .wr_data   (enq_data),
    .rd_idx    (head),
    .rd_addr   (deq_addr),
    .rd_data   (deq_data),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  stbuf_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head      (head),
    .count     (count),
    .key       (srch_addr),
    .hit       (srch_hit),
    .data      (srch_data)
  );

endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
  parameter int DEPTH = 4,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic          deq_valid,
  input logic          deq_ready,
  input logic [AW-1:0] deq_addr,
  input logic [DW-1:0] deq_data,
  input logic          srch_hit,
  input logic [DW-1:0] srch_data
);

  localparam int CW = $clog2(DEPTH + 1);

  // Occupancy rebuilt from the port handshakes alone.
  logic [CW-1:0] occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(enq_valid && enq_ready) - CW'(deq_valid && deq_ready);
  end

  // R9
  nonempty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid == (occ != '0));

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH) && !deq_ready) |-> !enq_ready);

  // R4
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH) && deq_ready) |-> enq_ready);

  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_addr) && $stable(deq_data)));

  // R6
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (!srch_hit && srch_data == '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

endmodule

bind stbuf_top stbuf_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_valid (enq_valid),
  .enq_ready (enq_ready),
  .deq_valid (deq_valid),
  .deq_ready (deq_ready),
  .deq_addr  (deq_addr),
  .deq_data  (deq_data),
  .srch_hit  (srch_hit),
  .srch_data (srch_data)
);

// File: tb/stbuf_top_test.sv
`timescale 1ns/1ps
module stbuf_top_test;

  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0;
  logic          enq_ready;
  logic [AW-1:0] enq_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic          deq_valid;
  logic          deq_ready = 1'b0;
  logic [AW-1:0] deq_addr;
  logic [DW-1:0] deq_data;
  logic [AW-1:0] srch_addr = '0;
  logic          srch_hit;
  logic [DW-1:0] srch_data;

  int checks = 0;
  int fails = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];

  always #2.5 clk = ~clk;

  stbuf_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Youngest matching entry of the model queue.
  function automatic logic [DW:0] model_search(logic [AW-1:0] a);
    for (int i = qa.size() - 1; i >= 0; i--)
      if (qa[i] == a) return {1'b1, qd[i]};
    return '0;
  endfunction

  task automatic step(bit ev, logic [AW-1:0] ea, logic [DW-1:0] ed, bit dr,
                      logic [AW-1:0] sa, string tag);
    logic [DW:0] exp_s;
    bit exp_rdy, ef, df;
    string rtag, stag;
    @(negedge clk);
    enq_valid = ev; enq_addr = ea; enq_data = ed; deq_ready = dr; srch_addr = sa;
    #1;
    exp_rdy = (qa.size() < DEPTH) || dr;
    rtag = (qa.size() < DEPTH) ? "R1" : (dr ? "R4" : "R3");
    check(rtag, enq_ready, exp_rdy);
    check("R9", deq_valid, qa.size() > 0);
    if (qa.size() > 0) begin
      check("R2", deq_addr, qa[0]);
      check("R2", deq_data, qd[0]);
    end
    exp_s = model_search(sa);
    stag = (tag != "") ? tag : (exp_s[DW] ? "R5" : "R6");
    check(stag, srch_hit, exp_s[DW]);
    check(stag, srch_data, exp_s[DW-1:0]);
    ef = ev && exp_rdy;
    df = dr && (qa.size() > 0);
    @(posedge clk);
    if (df) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (ef) begin qa.push_back(ea); qd.push_back(ed); end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", deq_valid, 0);
    check("R1", srch_hit, 0);
    check("R1", enq_ready, 1);

    // Fill with a repeated address
    step(1, 32'h100, 32'hD1, 0, 32'h100, "R7");
    step(1, 32'h104, 32'hD2, 0, 32'h100, "R5");
    step(1, 32'h100, 32'hD3, 0, 32'h100, "R5");
    step(1, 32'h108, 32'hD4, 0, 32'h100, "R5");
    // Full, drain held: store is refused
    step(1, 32'h10C, 32'hEE, 0, 32'h100, "R5");
    step(0, 0, 0, 0, 32'h10C, "R3");
    // Full, drain accepts: both transfer
    step(1, 32'h100, 32'hD5, 1, 32'h100, "R5");
    step(1, 32'h110, 32'hD6, 0, 32'h100, "R8");
    // Drain all; dequeued address no longer hits
    step(0, 0, 0, 1, 32'h104, "R5");
    step(0, 0, 0, 1, 32'h104, "R10");
    step(0, 0, 0, 1, 32'h100, "R8");
    step(0, 0, 0, 1, 32'h108, "R10");
    step(0, 0, 0, 0, 32'h100, "R10");
    // Search alongside enqueue of the same address
    step(1, 32'h200, 32'hA1, 0, 32'h200, "R7");
    step(0, 0, 0, 0, 32'h200, "R5");

    // Random traffic over a small address set
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 3) != 0, 32'h40 + (($urandom % 6) << 2), $urandom,
           ($urandom % 2) == 1, 32'h40 + (($urandom % 7) << 2),
           (qa.size() == DEPTH) ? "R8" : "");
    end
    finish_run();
  end

endmodule